// File: doc/BRIEF.md
# SPI Command-Byte Register Slave

This block is an SPI slave (clock idle low, data sampled on the rising SCK edge and changed on the falling edge) that gives an SPI master access to a small register file. The block is selected by an active-low chip select. Every transaction starts with a one-byte command. Bit 7 of the command is the direction flag, and the low bits name a register. A write command is followed by one data byte. A read command has no data byte, so the next byte in the same frame is decoded as a new command. The slave answers every received byte by shifting out the value of the register named by the previous command. Its reply is therefore always one command behind the master.

SCK, MOSI and chip select are sampled by a fast system clock through synchronizer stages. The lower part of the address space is a bank of control registers inside the block, laid out for block RAM. Each committed write is also presented as a one-cycle strobe on a parallel write port. The upper part of the address space is read-only status, which a separate status block supplies through an address/data read port. When the data of a status register has been captured for transmission after a read command, the block pulses a notification carrying that address, so the status block can clear its latched bits. A write is held until the chip select is released. It is committed only if the frame carried exactly sixteen SCK cycles.

Top module: `spi_cmd_regslave`

## Requirements
- R1: While the chip select is high, `spi_miso_oe` is low. It is high during a frame from a few system clocks after the select falls. After reset, `spi_miso_oe`, `spi_miso`, `wr_valid` and `stat_rd_done` are 0, and the output shift buffer holds 0.
- R2: Bits travel MSB first on both data lines. A command byte with bit 7 = 1 is a write and with bit 7 = 0 is a read. Bits 4:0 give the register address, and bits 6:5 are ignored.
- R3: For every complete byte of a frame, the slave shifts out the value of the register named by the most recent complete command byte. The buffer is reloaded only at the eighth falling SCK edge of a byte, so the first byte of a frame carries whatever was loaded at the end of the previous frame.
- R4: A write whose frame held exactly 16 SCK rising edges (command byte, then data byte) is committed when the chip select rises. The commit produces a one-cycle `wr_valid` with `wr_addr` and `wr_data`, and later reads of that address return the new value.
- R5: A frame with any other SCK count (for example 15, 17 or 24) commits nothing. A 16-bit frame that does not start with a write command plus its data byte also commits nothing.
- R6: Addresses 16 to 31 are read-only status. A write to them gives no `wr_valid` and leaves the value read back from them unchanged.
- R7: The chip select may stay low across several successive read commands. Each byte after a read command is decoded as a command.
- R8: A read of an address sent right after writing that address returns the old value while the write is still pending. Only a frame after the commit returns the new value.
- R9: `stat_rd_done` pulses for exactly one cycle, with `stat_rd_done_addr` set to the address, at the buffer reload that follows a read command addressing a status register. A read of a control register gives no pulse, and neither does a write command to a status register.
- R10: SCK edges while the chip select is high are ignored and do not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means released |
| wr_valid | output | 1 | One-cycle strobe for a committed control write |
| wr_addr | output | 5 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |
| stat_rd_addr | output | 5 | Address currently selected for readout |
| stat_rd_data | input | 8 | Status value at `stat_rd_addr` |
| stat_rd_done | output | 1 | One-cycle pulse when a status read was captured |
| stat_rd_done_addr | output | 5 | Status address that was captured |

## Verification
The hardest situation to reach from the ports is the shift buffer's content at the start of a frame. That content depends on the previous frame's last reload, and it becomes unpredictable when a frame stopped in the middle of a byte. The stimulus drives frames of arbitrary bit counts (15, 16, 17, 24, 40 and longer) back to back. The model tracks whether the buffer content is known, so that stale first bytes are predicted exactly after complete frames and skipped only after truncated ones. Write frames are followed directly by read frames of the same address, which exposes the window between a pending write and its commit on the select's rising edge.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_t;

  typedef struct packed {
    logic       is_wr;
    logic [6:0] rest;
  } cmd_t;

endpackage

// File: rtl/spi_rs_front.sv
module spi_rs_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic cs_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic cs_rise,
  output logic mosi_s
);

  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b100;

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] synced;
  logic [SYNC_STAGES-1:0] chain [NSIG];

  assign raw_in = {cs_n_i, mosi_i, sck_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= {SYNC_STAGES{RST_VAL[g]}};
      else     chain[g] <= {chain[g][SYNC_STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = chain[g][SYNC_STAGES-1];
  end

  logic sck_d, cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      cs_d     <= 1'b1;
      sck_rise <= 1'b0;
      sck_fall <= 1'b0;
      sel      <= 1'b0;
      cs_rise  <= 1'b0;
      mosi_s   <= 1'b0;
    end else begin
      sck_d    <= synced[0];
      cs_d     <= synced[2];
      sck_rise <= synced[0] & ~sck_d;
      sck_fall <= ~synced[0] & sck_d;
      sel      <= ~synced[2];
      cs_rise  <= synced[2] & ~cs_d;
      mosi_s   <= synced[1];
    end
  end

endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
  import spi_rs_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int CTRL_REGS = 16,
  parameter int FB_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sel,
  input  logic              cs_rise,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              reload,
  output logic              shift,
  output logic              stat_done,
  output logic [ADDR_W-1:0] stat_done_addr,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTE_W-1:0] commit_data,
  output logic [FB_W-1:0]   frame_bits
);

  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_REGS);
  localparam logic [FB_W-1:0]   WR_BITS  = FB_W'(2 * BYTE_W);

  logic [2:0]        bit_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_end;
  logic              byte_pend;
  logic              armed;
  logic              stat_pend;
  phase_t            phase;
  logic [ADDR_W-1:0] wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  cmd_t              cmd;
  logic [ADDR_W-1:0] cmd_addr;
  logic              spare_unused;

  assign rx_byte      = {rx_sh, mosi_s};
  assign cmd          = rx_byte;
  assign cmd_addr     = cmd.rest[ADDR_W-1:0];
  assign spare_unused = ^cmd.rest[6:ADDR_W];
  assign byte_end     = sck_rise && (bit_cnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt        <= '0;
      rx_sh          <= '0;
      byte_pend      <= 1'b0;
      armed          <= 1'b0;
      stat_pend      <= 1'b0;
      phase          <= PH_CMD;
      wr_addr_q      <= '0;
      wr_data_q      <= '0;
      cur_addr       <= '0;
      reload         <= 1'b0;
      shift          <= 1'b0;
      stat_done      <= 1'b0;
      stat_done_addr <= '0;
      commit         <= 1'b0;
      commit_addr    <= '0;
      commit_data    <= '0;
      frame_bits     <= '0;
    end else begin
      reload    <= 1'b0;
      shift     <= 1'b0;
      stat_done <= 1'b0;
      commit    <= 1'b0;
      if (!sel) begin
        bit_cnt    <= '0;
        frame_bits <= '0;
        byte_pend  <= 1'b0;
        armed      <= 1'b0;
        stat_pend  <= 1'b0;
        phase      <= PH_CMD;
        if (cs_rise && armed && (frame_bits == WR_BITS) && (wr_addr_q < CTRL_LIM)) begin
          commit      <= 1'b1;
          commit_addr <= wr_addr_q;
          commit_data <= wr_data_q;
        end
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_byte[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (frame_bits != '1) frame_bits <= frame_bits + FB_W'(1);
        end
        if (byte_end) begin
          byte_pend <= 1'b1;
          if (phase == PH_CMD) begin
            cur_addr <= cmd_addr;
            armed    <= 1'b0;
            if (cmd.is_wr) begin
              phase     <= PH_DATA;
              wr_addr_q <= cmd_addr;
              stat_pend <= 1'b0;
            end else begin
              stat_pend <= (cmd_addr >= CTRL_LIM);
            end
          end else begin
            wr_data_q <= rx_byte;
            armed     <= 1'b1;
            phase     <= PH_CMD;
            stat_pend <= 1'b0;
          end
        end
        if (sck_fall) begin
          if (byte_pend) begin
            reload         <= 1'b1;
            byte_pend      <= 1'b0;
            stat_done      <= stat_pend;
            stat_done_addr <= cur_addr;
            stat_pend      <= 1'b0;
          end else begin
            shift <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_rs_tx.sv
module spi_rs_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         reload,
  input  logic         shift,
  input  logic [W-1:0] load_val,
  output logic         miso,
  output logic         miso_oe
);

  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= sel;
      if (reload)     sh <= load_val;
      else if (shift) sh <= {sh[W-2:0], 1'b0};
    end
  end

  assign miso = sh[W-1];

endmodule

// File: rtl/spi_cmd_regslave.sv
module spi_cmd_regslave
  import spi_rs_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int CTRL_REGS   = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FB_W        = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] stat_rd_addr,
  input  logic [7:0]        stat_rd_data,
  output logic              stat_rd_done,
  output logic [ADDR_W-1:0] stat_rd_done_addr
);

  localparam int IDX_W = $clog2(CTRL_REGS);
  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_REGS);

  logic              sck_rise, sck_fall, sel, cs_rise, mosi_s;
  logic [ADDR_W-1:0] cur_addr;
  logic              reload, shift;
  logic [FB_W-1:0]   frame_bits;
  logic [BYTE_W-1:0] mem_q, stat_q, load_val;
  logic              src_stat_q;

  spi_rs_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst      (rst),
    .sck_i    (spi_sck),
    .mosi_i   (spi_mosi),
    .cs_n_i   (spi_cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sel      (sel),
    .cs_rise  (cs_rise),
    .mosi_s   (mosi_s)
  );

  spi_rs_frame #(.ADDR_W(ADDR_W), .CTRL_REGS(CTRL_REGS), .FB_W(FB_W)) u_frame (
    .clk            (clk),
    .rst            (rst),
    .sck_rise       (sck_rise),
    .sck_fall       (sck_fall),
    .sel            (sel),
    .cs_rise        (cs_rise),
    .mosi_s         (mosi_s),
    .cur_addr       (cur_addr),
    .reload         (reload),
    .shift          (shift),
    .stat_done      (stat_rd_done),
    .stat_done_addr (stat_rd_done_addr),
    .commit         (wr_valid),
    .commit_addr    (wr_addr),
    .commit_data    (wr_data),
    .frame_bits     (frame_bits)
  );

  spi_rs_regfile #(.DEPTH(CTRL_REGS), .DATA_W(BYTE_W)) u_regs (
    .clk   (clk),
    .we    (wr_valid),
    .waddr (wr_addr[IDX_W-1:0]),
    .wdata (wr_data),
    .raddr (cur_addr[IDX_W-1:0]),
    .rdata (mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_stat_q <= 1'b0;
      stat_q     <= '0;
    end else begin
      src_stat_q <= (cur_addr >= CTRL_LIM);
      stat_q     <= stat_rd_data;
    end
  end

  assign load_val     = src_stat_q ? stat_q : mem_q;
  assign stat_rd_addr = cur_addr;

  spi_rs_tx #(.W(BYTE_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .reload   (reload),
    .shift    (shift),
    .load_val (load_val),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

endmodule

// File: rtl/spi_rs_chk.sv
module spi_rs_chk #(
  parameter int ADDR_W    = 5,
  parameter int CTRL_REGS = 16,
  parameter int FB_W      = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sel,
  input logic              cs_rise,
  input logic              sck_fall,
  input logic [FB_W-1:0]   frame_bits,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              stat_rd_done,
  input logic [ADDR_W-1:0] stat_rd_done_addr
);

  localparam logic [ADDR_W-1:0] CTRL_LIM = ADDR_W'(CTRL_REGS);
  localparam logic [FB_W-1:0]   WR_BITS  = FB_W'(16);

  // R1
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !spi_miso_oe);

  // R3
  miso_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sck_fall, 2) |-> $stable(spi_miso));

  // R4
  commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> $past(cs_rise));

  // R5
  commit_count_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> ($past(frame_bits) == WR_BITS));

  // R6
  commit_rw_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr < CTRL_LIM));

  // R9
  stat_addr_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd_done |-> (stat_rd_done_addr >= CTRL_LIM));

  // R9
  stat_fall_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd_done |-> $past(sck_fall));

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_valid, stat_rd_done}));

endmodule

bind spi_cmd_regslave spi_rs_chk #(
  .ADDR_W    (ADDR_W),
  .CTRL_REGS (CTRL_REGS),
  .FB_W      (FB_W)
) u_chk (
  .clk               (clk),
  .rst               (rst),
  .sel               (sel),
  .cs_rise           (cs_rise),
  .sck_fall          (sck_fall),
  .frame_bits        (frame_bits),
  .spi_miso          (spi_miso),
  .spi_miso_oe       (spi_miso_oe),
  .wr_valid          (wr_valid),
  .wr_addr           (wr_addr),
  .stat_rd_done      (stat_rd_done),
  .stat_rd_done_addr (stat_rd_done_addr)
);

// File: tb/spi_cmd_regslave_bench.sv
module spi_cmd_regslave_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NCTRL      = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic spi_miso, spi_miso_oe, wr_valid, stat_rd_done;
  logic [4:0] wr_addr, stat_rd_addr, stat_rd_done_addr;
  logic [7:0] wr_data, stat_rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] stat_val(input logic [4:0] a);
    return {a, 3'b011} ^ 8'hC3;
  endfunction

  assign stat_rd_data = stat_val(stat_rd_addr);

  spi_cmd_regslave u_spi_cmd_regslave (
    .clk               (clk),
    .rst               (rst),
    .spi_sck           (sck),
    .spi_mosi          (mosi),
    .spi_cs_n          (cs_n),
    .spi_miso          (spi_miso),
    .spi_miso_oe       (spi_miso_oe),
    .wr_valid          (wr_valid),
    .wr_addr           (wr_addr),
    .wr_data           (wr_data),
    .stat_rd_addr      (stat_rd_addr),
    .stat_rd_data      (stat_rd_data),
    .stat_rd_done      (stat_rd_done),
    .stat_rd_done_addr (stat_rd_done_addr)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0]  mem_m [NCTRL];
  bit          mem_v [NCTRL];
  int          cur_m    = 0;
  logic [7:0]  tx_m     = 8'h00;
  bit          tx_known = 1'b1;
  logic [12:0] wr_q  [$];
  logic [4:0]  st_q  [$];
  logic [7:0]  out_q [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // cycle-by-cycle comparison of the strobes against the model queues
  logic [12:0] exp_w;
  logic [4:0]  exp_s;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (wr_valid) begin
        if (wr_q.size() == 0) check(1'b0, "R4/R5/R6", "unexpected write", int'({wr_addr, wr_data}), 0);
        else begin
          exp_w = wr_q.pop_front();
          check({wr_addr, wr_data} === exp_w, "R4", "write strobe", int'({wr_addr, wr_data}), int'(exp_w));
        end
      end
      if (stat_rd_done) begin
        if (st_q.size() == 0) check(1'b0, "R9", "unexpected status pulse", int'(stat_rd_done_addr), 0);
        else begin
          exp_s = st_q.pop_front();
          check(stat_rd_done_addr === exp_s, "R9", "status pulse address", int'(stat_rd_done_addr), int'(exp_s));
        end
      end
    end
  end

  task automatic run_frame(input int nbits, input string req);
    int ph = 0;
    bit armed = 1'b0;
    int waddr = 0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rxb = 8'h00;
    logic [7:0] v;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      v = out_q[i / 8];
      mosi = v[7 - (i % 8)];
      repeat (HALF) @(negedge clk);
      if (i == 0) check(spi_miso_oe === 1'b1, "R1", "oe inside frame", int'(spi_miso_oe), 1);
      rxb = {rxb[6:0], spi_miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
      if (i % 8 == 7) begin
        if (tx_known) check(rxb === tx_m, req, "reply byte", int'(rxb), int'(tx_m));
        if (ph == 0) begin
          cur_m = int'(v[4:0]);
          armed = 1'b0;
          if (v[7]) begin
            ph = 1;
            waddr = int'(v[4:0]);
          end else if (cur_m >= NCTRL) begin
            st_q.push_back(v[4:0]);
          end
        end else begin
          wdata = v;
          armed = 1'b1;
          ph = 0;
        end
        if (cur_m < NCTRL) begin
          tx_m = mem_m[cur_m];
          tx_known = mem_v[cur_m];
        end else begin
          tx_m = stat_val(5'(cur_m));
          tx_known = 1'b1;
        end
      end
    end
    if (nbits % 8 != 0) tx_known = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    if (nbits == 16 && armed && waddr < NCTRL) begin
      mem_m[waddr] = wdata;
      mem_v[waddr] = 1'b1;
      wr_q.push_back({5'(waddr), wdata});
    end
    repeat (3 * HALF) @(negedge clk);
    check(spi_miso_oe === 1'b0, "R1", "oe released", int'(spi_miso_oe), 0);
    out_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0h expected %0h", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCTRL; i++) mem_v[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(spi_miso_oe === 1'b0, "R1", "reset oe", int'(spi_miso_oe), 0);
    check(spi_miso === 1'b0, "R1", "reset miso", int'(spi_miso), 0);
    check(wr_valid === 1'b0, "R1", "reset wr_valid", int'(wr_valid), 0);
    check(stat_rd_done === 1'b0, "R1", "reset stat pulse", int'(stat_rd_done), 0);

    // R2, R4: fill every control register, spare command bits varied
    for (int i = 0; i < NCTRL; i++) begin
      out_q.push_back(8'h80 | 8'((i % 4) << 5) | 8'(i));
      out_q.push_back(8'h5A ^ 8'(i * 19));
      run_frame(16, "R2");
    end

    // R3, R7, R9: chained reads under one select, one of them status
    out_q = '{8'h02, 8'h05, 8'h14, 8'h07, 8'h60};
    run_frame(40, "R7");

    // R8: readback straight after a write
    out_q = '{8'h84, 8'h3C};
    run_frame(16, "R4");
    out_q = '{8'h04, 8'h04};
    run_frame(16, "R8");

    // R5: wrong packet lengths
    out_q = '{8'h89, 8'hEE};
    run_frame(15, "R5");
    out_q = '{8'h89, 8'hEE, 8'h00};
    run_frame(17, "R5");
    out_q = '{8'h89, 8'hEE, 8'h09};
    run_frame(24, "R5");
    out_q = '{8'h09, 8'h09};
    run_frame(16, "R5");

    // R6: write to read-only status address 21
    out_q = '{8'h95, 8'hFF};
    run_frame(16, "R6");
    out_q = '{8'h15, 8'h01};
    run_frame(16, "R6");

    // R10: clock edges with select high
    for (int k = 0; k < 5; k++) begin
      mosi = k[0];
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    out_q = '{8'h86, 8'h77};
    run_frame(16, "R10");
    out_q = '{8'h06, 8'h06};
    run_frame(16, "R10");

    // R7: read followed by a write command in 16 bits commits nothing
    out_q = '{8'h03, 8'h83};
    run_frame(16, "R7");

    // R3: full readback, ending with a status read
    for (int i = 0; i < NCTRL; i++) out_q.push_back(8'(i));
    out_q.push_back(8'h1F);
    run_frame(136, "R3");

    repeat (20) @(negedge clk);
    check(wr_q.size() == 0, "R4", "pending writes", wr_q.size(), 0);
    check(st_q.size() == 0, "R9", "pending status pulses", st_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule